// File: doc/BRIEF.md
# Touch-Gated Conversion Interval Timer

This block decides when a touchscreen digitizer starts its next conversion sequence. After each sequence finishes it may count a programmable interval and then ask for a new sequence. The count runs on a 0.5 µs tick delivered as a clock enable. An 8-bit interval code picks the length: code 0 means one-shot operation, and codes 1 to 255 give a fixed base length plus a fixed step per code. The block's only output is a one-cycle start request.

Two operating modes exist. In slave operation the count always restarts when a sequence completes. In master operation the count runs only while the screen is touched. Losing touch cancels it. A new touch requests a sequence at once. Any change of the interval code or of the mode discards a count in progress.

Top module: `conv_interval_timer`

## Requirements
- R1: With interval code 0, a sequence-done pulse starts no count, and no start request follows it.
- R2: For codes 1 to 255, the interval is 1100 + 70·(code−1) ticks: 1100 for code 1, 1170 for code 2, 18880 for code 255. The start request appears in the cycle after the edge that samples the last tick of that count.
- R3: The count advances only at clock edges where tick_en is high. Cycles without a tick leave the remaining count unchanged.
- R4: In slave operation (master_mode low), a sequence-done pulse starts the count whatever the touch level.
- R5: In master operation (master_mode high), a sequence-done pulse with touch low starts nothing. Touch going low during a count cancels it, and no start request is issued while touch is low.
- R6: In master operation, a low-to-high change of touch produces a start request in the next cycle, without waiting for an interval.
- R7: Any change of interval_code or master_mode discards a count in progress. No start request follows the edge at which the change is seen.
- R8: start_req lasts exactly one cycle. After a request, no further interval request comes until a new sequence-done pulse arrives.
- R9: While rst_n is low, and right after reset, start_req is low and no count is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 0.5 µs tick enable (2 MHz) |
| interval_code | input | 8 | Interval code; 0 means one-shot |
| master_mode | input | 1 | 1 = master (touch-gated), 0 = slave |
| touch | input | 1 | Touch-present level |
| seq_done | input | 1 | One-cycle pulse at the end of a conversion sequence |
| start_req | output | 1 | One-cycle request to start a new sequence |

## Verification
Every result is registered once, so it shows on start_req in the cycle after the clock edge that samples its cause. A touch rise, a configuration change or a loss of touch takes effect one cycle later. An expiring interval shows one cycle after the edge that samples its last tick, which is N ticked edges after the edge that samples seq_done. The bench drives inputs on the falling edge and keeps a cycle model, updated on the rising edge, that follows these rules. It compares start_req against that model on every falling edge. Directed interval checks count falling edges from the seq_done pulse, so a code-N interval is expected at N+1 falling edges.

// File: rtl/cit_pkg.sv
package cit_pkg;

    // Decision taken by the timer in a given cycle, in priority order.
    typedef enum logic [2:0] {
        CIT_EV_IDLE   = 3'd0,
        CIT_EV_CLEAR  = 3'd1,
        CIT_EV_TOUCH  = 3'd2,
        CIT_EV_LOAD   = 3'd3,
        CIT_EV_REFUSE = 3'd4,
        CIT_EV_DROP   = 3'd5,
        CIT_EV_EXPIRE = 3'd6,
        CIT_EV_STEP   = 3'd7
    } cit_event_e;

    // Longest interval in ticks for a given code width.
    function automatic int cit_max_ticks(input int base, input int step, input int code_w);
        return base + step * ((1 << code_w) - 2);
    endfunction

endpackage

// File: rtl/cit_cfg_watch.sv
module cit_cfg_watch #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              master_i,
    output logic              cfg_changed_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              master;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.code   = code_i;
        st_d.master = master_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_changed_o = (code_i != st_q.code) || (master_i != st_q.master);

endmodule

// File: rtl/cit_touch_edge.sv
module cit_touch_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic touch_i,
    output logic rise_o
);

    logic seen_d, seen_q;

    always_comb begin
        seen_d = touch_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign rise_o = touch_i && !seen_q;

endmodule

// File: rtl/cit_interval_calc.sv
module cit_interval_calc #(
    parameter int CODE_W     = 8,
    parameter int BASE_TICKS = 1100,
    parameter int STEP_TICKS = 70,
    parameter int CNT_W      = 15
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              repeat_o,
    output logic [CNT_W-1:0]  load_o
);

    localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE_TICKS);
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_TICKS);

    logic [CNT_W-1:0] code_ext;
    logic [CNT_W-1:0] steps;

    always_comb begin
        code_ext = CNT_W'(code_i);
        repeat_o = (code_i != '0);
        steps    = repeat_o ? (code_ext - CNT_W'(1)) : '0;
        load_o   = repeat_o ? (BASE_C + STEP_C * steps) : '0;
    end

endmodule

// File: rtl/conv_interval_timer.sv
module conv_interval_timer #(
    parameter int CODE_W     = 8,
    parameter int BASE_TICKS = 1100,
    parameter int STEP_TICKS = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] interval_code,
    input  logic              master_mode,
    input  logic              touch,
    input  logic              seq_done,
    output logic              start_req
);
    import cit_pkg::*;

    localparam int CNT_W = $clog2(cit_max_ticks(BASE_TICKS, STEP_TICKS, CODE_W) + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] remain;
        logic             req;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    cit_event_e ev;

    logic             cfg_changed;
    logic             touch_rise;
    logic             repeat_on;
    logic [CNT_W-1:0] load_val;

    cit_cfg_watch #(.CODE_W(CODE_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .code_i       (interval_code),
        .master_i     (master_mode),
        .cfg_changed_o(cfg_changed)
    );

    cit_touch_edge u_touch (
        .clk    (clk),
        .rst_n  (rst_n),
        .touch_i(touch),
        .rise_o (touch_rise)
    );

    cit_interval_calc #(
        .CODE_W    (CODE_W),
        .BASE_TICKS(BASE_TICKS),
        .STEP_TICKS(STEP_TICKS),
        .CNT_W     (CNT_W)
    ) u_calc (
        .code_i  (interval_code),
        .repeat_o(repeat_on),
        .load_o  (load_val)
    );

    // Event selection, highest priority first.
    always_comb begin
        if (cfg_changed) begin
            ev = CIT_EV_CLEAR;
        end else if (master_mode && touch_rise) begin
            ev = CIT_EV_TOUCH;
        end else if (seq_done) begin
            ev = (repeat_on && (!master_mode || touch)) ? CIT_EV_LOAD : CIT_EV_REFUSE;
        end else if (st_q.armed && master_mode && !touch) begin
            ev = CIT_EV_DROP;
        end else if (st_q.armed && tick_en) begin
            ev = (st_q.remain == CNT_W'(1)) ? CIT_EV_EXPIRE : CIT_EV_STEP;
        end else begin
            ev = CIT_EV_IDLE;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        unique case (ev)
            CIT_EV_CLEAR, CIT_EV_REFUSE, CIT_EV_DROP: begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
            end
            CIT_EV_TOUCH, CIT_EV_EXPIRE: begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
                st_d.req    = 1'b1;
            end
            CIT_EV_LOAD: begin
                st_d.armed  = 1'b1;
                st_d.remain = load_val;
            end
            CIT_EV_STEP: begin
                st_d.remain = st_q.remain - CNT_W'(1);
            end
            default: begin
                st_d = st_d;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_req = st_q.req;

endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] interval_code,
    input logic              master_mode,
    input logic              touch,
    input logic              start_req
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req); // R8

    AST_ONESHOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && interval_code == '0) |=> !start_req); // R1

    AST_NO_TOUCH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !touch) |=> !start_req); // R5

    AST_TOUCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && touch && !$past(touch) && $stable(master_mode)
         && $stable(interval_code)) |=> start_req); // R6

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(interval_code) || !$stable(master_mode)) |=> !start_req); // R7

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!start_req); // R9
        end
    end

endmodule

bind conv_interval_timer cit_checker #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .interval_code(interval_code),
    .master_mode  (master_mode),
    .touch        (touch),
    .start_req    (start_req)
);

// File: tb/conv_interval_timer_tb.sv
module conv_interval_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] interval_code = 8'd0;
    logic       master_mode = 1'b0;
    logic       touch = 1'b0;
    logic       seq_done = 1'b0;
    logic       start_req;

    int tests = 0;
    int fails = 0;
    int req_seen = 0;
    int cycles = 0;
    string phase = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .interval_code(interval_code),
        .master_mode(master_mode), .touch(touch), .seq_done(seq_done), .start_req(start_req)
    );

    function automatic int exp_ticks(input int code);
        return 1100 + 70 * (code - 1);
    endfunction

    // Cycle model built from the requirements.
    int   m_cnt = 0;
    bit   m_armed = 0, m_req = 0, m_ptouch = 0, m_pmaster = 0;
    int   m_pcode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_armed <= 0; m_req <= 0;
            m_ptouch <= 0; m_pmaster <= 0; m_pcode <= 0;
        end else begin
            bit req_n, armed_n;
            int cnt_n;
            req_n = 0; armed_n = m_armed; cnt_n = m_cnt;
            if (int'(interval_code) != m_pcode || master_mode != m_pmaster) begin
                armed_n = 0;
            end else if (master_mode && touch && !m_ptouch) begin
                req_n = 1; armed_n = 0;
            end else if (seq_done) begin
                if (interval_code != 0 && (!master_mode || touch)) begin
                    armed_n = 1; cnt_n = exp_ticks(int'(interval_code));
                end else armed_n = 0;
            end else if (m_armed && master_mode && !touch) begin
                armed_n = 0;
            end else if (m_armed && tick_en) begin
                if (m_cnt == 1) begin req_n = 1; armed_n = 0; end
                else cnt_n = m_cnt - 1;
            end
            m_req <= req_n; m_armed <= armed_n; m_cnt <= cnt_n;
            m_ptouch <= touch; m_pmaster <= master_mode; m_pcode <= int'(interval_code);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (start_req) req_seen++;
        if (rst_n) check(phase, int'(start_req), int'(m_req));
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
    endtask

    // Latency from seq_done to start_req, in falling edges minus one.
    task automatic measure(input int code, input string req);
        int n;
        interval_code = 8'(code); master_mode = 1'b0; tick_en = 1'b1;
        step(3);
        @(negedge clk); seq_done = 1'b1;
        n = 0;
        do begin
            @(negedge clk); seq_done = 1'b0; n++;
        end while (!start_req && n < 20000);
        check(req, n - 1, exp_ticks(code));
        @(negedge clk);
        check("R8", int'(start_req), 0);
    endtask

    initial begin
        int base;
        process::self().srandom(32'h5eed_1234);
        step(4);
        check("R9", int'(start_req), 0);
        rst_n = 1'b1;
        step(2);
        check("R9", int'(start_req), 0);

        phase = "R2";
        measure(1, "R2");
        measure(2, "R2");
        measure(255, "R2");
        phase = "R8";
        base = req_seen; step(3000);
        check("R8", req_seen - base, 0);

        phase = "R1";
        interval_code = 8'd0; step(3); base = req_seen;
        pulse_done(); step(3000);
        check("R1", req_seen - base, 0);

        phase = "R3";
        interval_code = 8'd1; tick_en = 1'b0; step(3); base = req_seen;
        pulse_done(); step(3000);
        check("R3", req_seen - base, 0);
        tick_en = 1'b1; step(1105);
        check("R3", req_seen - base, 1);

        phase = "R4";
        touch = 1'b0; base = req_seen; pulse_done(); step(1105);
        check("R4", req_seen - base, 1);

        phase = "R6";
        master_mode = 1'b1; step(3); base = req_seen;
        @(negedge clk); touch = 1'b1;
        @(negedge clk);
        check("R6", int'(start_req), 1);
        phase = "R5";
        @(negedge clk); touch = 1'b0; step(2); base = req_seen;
        pulse_done(); step(1200);
        check("R5", req_seen - base, 0);
        @(negedge clk); touch = 1'b1; step(2);
        base = req_seen; pulse_done(); step(500);
        @(negedge clk); touch = 1'b0; step(1000);
        check("R5", req_seen - base, 0);

        phase = "R7";
        master_mode = 1'b0; step(3); base = req_seen;
        pulse_done(); step(500);
        interval_code = 8'd2; step(2000);
        check("R7", req_seen - base, 0);
        pulse_done(); step(500);
        master_mode = 1'b1; touch = 1'b1; step(2000);
        check("R7", req_seen - base, 0);

        phase = "R2 R3 R4 R5 R6 R7 R8";
        for (int c = 0; c < 70000; c++) begin
            @(negedge clk);
            tick_en  = ($urandom % 4) != 0;
            seq_done = start_req ? 1'b0 : (($urandom % 1500) == 0);
            if (($urandom % 600) == 0) touch = ~touch;
            if (($urandom % 6000) == 0) interval_code = 8'($urandom % 5);
            if (($urandom % 9000) == 0) master_mode = ~master_mode;
            if (start_req) begin
                for (int k = 0; k < 20; k++) @(negedge clk);
                seq_done = 1'b1;
            end
        end
        @(negedge clk); seq_done = 1'b0;
        step(2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule